// File: doc/BRIEF.md
# Interrupt Notification Message Generator

This block watches a set of level-signalled interrupt sources and turns each new assertion into one 64-bit memory write. The write goes to a programmable notification address. Its payload is a logical interrupt number, formed as a programmable numbering base plus the source index, and is placed on the data bus in big-endian byte order. Software sets up the block through a small 64-bit register port. That port holds a control word, a scratch base for an event buffer, the notification address with its enable flag, the numbering base, and a read-only view of the latched source levels.

Source tracking keeps one latched level per source. A rising edge on a source arms one pending request, and the source cannot arm again until its level falls and rises once more. A send state machine grants pending requests one at a time, lowest source index first. It has two states. In IDLE, when any request is pending and the address enable is set, it grants the lowest pending source, captures the address and payload, and moves to SEND. When a request is pending but the address enable is clear, it discards every pending request and stays in IDLE. In SEND, it presents the write with valid asserted and returns to IDLE in the cycle the receiver asserts ready.

The control word carries two flags. One selects a level-signalled delivery method that this block refuses: while that flag is set, source changes are not taken in and a refusal flag is raised. The other is a self-clearing request that wipes all source state.

Top module: `irqn_notify_gen`

## Requirements
- R1: After reset, `nw_valid` and `src_refused` are 0, and the control (0x58), event base (0x60), notification address (0x68), numbering base (0x70) and level (0x78) registers all read 0.
- R2: Offsets 0x60, 0x68 and 0x70 read back the full 64-bit value last written. A write to the level register (0x78) has no effect. Any other offset, including any offset whose low three bits are not zero, reads all ones.
- R3: While control bit 63 is 0, level register bit (63 - n) equals the level of source n, one clock after that level is applied.
- R4: A rising edge on source n produces exactly one write. Its address is the notification address with bit 0 cleared. Its data is the 64-bit value (numbering base bits [63:32] + n) with the bytes reversed, so the most significant byte sits in `nw_data[7:0]`. `nw_valid` first rises two clocks after the edge is applied.
- R5: A source that stays high produces no further writes until it falls and rises again.
- R6: While notification address bit 0 is 0, pending requests are discarded and no write is issued. Setting the bit later does not revive them.
- R7: When several requests are pending, the writes go out in ascending source index.
- R8: While `nw_valid` is 1 and `nw_ready` is 0, `nw_valid`, `nw_addr` and `nw_data` hold their values.
- R9: While control bit 63 is 1, the level register holds its value, no new request is armed, and `src_refused` is 1 whenever any source level differs from its latched level. Once bit 63 is cleared, a source that rose in the meantime produces its write.
- R10: A control write with bit 62 set clears all pending requests and the level register, but leaves a write already presented intact. Bit 62 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level | input | 20 | Interrupt source levels, bit n is source n |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for `cfg_addr` (combinational) |
| src_refused | output | 1 | A source change is being refused in level-signalled mode |
| nw_valid | output | 1 | Notification write request valid |
| nw_ready | input | 1 | Receiver accepts the write |
| nw_addr | output | 64 | Notification write address |
| nw_data | output | 64 | Notification write payload, big-endian |

## Verification
The hardest state to reach is a clear request that arrives while one write is stalled at the port and another request is still queued behind it. To get there, the stimulus holds `nw_ready` low, raises two sources at once, and lowers them again so that no fresh edge can re-arm them. It then issues the clear and releases `nw_ready`. Exactly one write must come out. Randomised rounds raise random groups of sources under a stalled receiver, with random addresses and numbering bases, and check that the order and payloads match the lowest-index-first rule.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

    localparam int OFS_CTRL   = 'h58;
    localparam int OFS_EVBASE = 'h60;
    localparam int OFS_NADDR  = 'h68;
    localparam int OFS_NBASE  = 'h70;
    localparam int OFS_LEVEL  = 'h78;

    localparam int CTRL_METHOD_BIT = 63;
    localparam int CTRL_CLEAR_BIT  = 62;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } send_state_t;

    function automatic logic [63:0] swap_bytes(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) begin
            r[8*k +: 8] = v[8*(7-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irqn_regs.sv
module irqn_regs
    import irqn_pkg::*;
#(
    parameter int AW      = 8,
    parameter int NUM_SRC = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [63:0]        cfg_wdata,
    output logic [63:0]        cfg_rdata,
    input  logic [NUM_SRC-1:0] level_q,
    output logic               method_lvl,
    output logic               clear_req,
    output logic [63:0]        notif_addr,
    output logic [31:0]        num_base
);

    logic [63:0] ctrl_q;
    logic [63:0] evbase_q;
    logic [63:0] naddr_q;
    logic [63:0] nbase_q;
    logic [63:0] lvl_word;

    logic hit_ctrl, hit_evbase, hit_naddr, hit_nbase;

    always_comb begin
        hit_ctrl   = (cfg_addr == AW'(OFS_CTRL));
        hit_evbase = (cfg_addr == AW'(OFS_EVBASE));
        hit_naddr  = (cfg_addr == AW'(OFS_NADDR));
        hit_nbase  = (cfg_addr == AW'(OFS_NBASE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            evbase_q <= '0;
            naddr_q  <= '0;
            nbase_q  <= '0;
        end else if (cfg_wr) begin
            if (hit_ctrl) begin
                ctrl_q <= cfg_wdata & ~(64'd1 << CTRL_CLEAR_BIT);
            end
            if (hit_evbase) begin
                evbase_q <= cfg_wdata;
            end
            if (hit_naddr) begin
                naddr_q <= cfg_wdata;
            end
            if (hit_nbase) begin
                nbase_q <= cfg_wdata;
            end
        end
    end

    always_comb begin
        lvl_word = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            lvl_word[63-n] = level_q[n];
        end
    end

    always_comb begin
        if (cfg_addr == AW'(OFS_CTRL)) begin
            cfg_rdata = ctrl_q;
        end else if (cfg_addr == AW'(OFS_EVBASE)) begin
            cfg_rdata = evbase_q;
        end else if (cfg_addr == AW'(OFS_NADDR)) begin
            cfg_rdata = naddr_q;
        end else if (cfg_addr == AW'(OFS_NBASE)) begin
            cfg_rdata = nbase_q;
        end else if (cfg_addr == AW'(OFS_LEVEL)) begin
            cfg_rdata = lvl_word;
        end else begin
            cfg_rdata = '1;
        end
    end

    assign method_lvl = ctrl_q[CTRL_METHOD_BIT];
    assign clear_req  = cfg_wr && hit_ctrl && cfg_wdata[CTRL_CLEAR_BIT];
    assign notif_addr = naddr_q;
    assign num_base   = nbase_q[63:32];

    // R10: the clear flag never remains stored in the control word
    p_clear_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !ctrl_q[CTRL_CLEAR_BIT]);

endmodule

// File: rtl/irqn_src_track.sv
module irqn_src_track #(
    parameter int NUM_SRC = 20,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               method_lvl,
    input  logic               clear_req,
    input  logic               grant,
    input  logic               drop_all,
    output logic [NUM_SRC-1:0] level_q,
    output logic               pend_any,
    output logic [IDX_W-1:0]   pend_idx,
    output logic               refused
);

    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] grant_mask;
    logic [NUM_SRC-1:0] pend_nxt;
    logic [NUM_SRC-1:0] lvl_nxt;

    assign rise = method_lvl ? '0 : (src_level & ~level_q);

    always_comb begin
        pend_idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (pending[n]) begin
                pend_idx = IDX_W'(n);
            end
        end
    end

    assign pend_any = |pending;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_gmask
            assign grant_mask[g] = grant && (pend_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        if (clear_req) begin
            pend_nxt = '0;
            lvl_nxt  = '0;
        end else begin
            pend_nxt = drop_all ? '0 : ((pending & ~grant_mask) | rise);
            lvl_nxt  = method_lvl ? level_q : src_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
            level_q <= '0;
        end else begin
            pending <= pend_nxt;
            level_q <= lvl_nxt;
        end
    end

    assign refused = method_lvl && (src_level != level_q);

    // R7: a grant always goes to the lowest pending source
    p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((pending & ((NUM_SRC'(1) << pend_idx) - NUM_SRC'(1))) == '0));

    // R7: at most one source is granted per cycle
    p_grant_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_mask));

    // R9: level-signalled method arms no new requests
    p_method_no_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        method_lvl |=> ((pending & ~$past(pending)) == '0));

    // R9: level register frozen while the method bit is set
    p_method_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (method_lvl && !clear_req) |=> $stable(level_q));

endmodule

// File: rtl/irqn_sender.sv
module irqn_sender
    import irqn_pkg::*;
#(
    parameter int NUM_SRC = 20,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_any,
    input  logic [IDX_W-1:0] pend_idx,
    input  logic [63:0]      notif_addr,
    input  logic [31:0]      num_base,
    output logic             grant,
    output logic             drop_all,
    output logic             nw_valid,
    input  logic             nw_ready,
    output logic [63:0]      nw_addr,
    output logic [63:0]      nw_data
);

    send_state_t state_q, state_d;
    logic        addr_ok;

    assign addr_ok = notif_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        grant    = 1'b0;
        drop_all = 1'b0;
        nw_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (pend_any) begin
                    if (addr_ok) begin
                        grant   = 1'b1;
                        state_d = S_SEND;
                    end else begin
                        drop_all = 1'b1;
                    end
                end
            end
            S_SEND: begin
                nw_valid = 1'b1;
                if (nw_ready) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nw_addr <= '0;
            nw_data <= '0;
        end else if (grant) begin
            nw_addr <= {notif_addr[63:1], 1'b0};
            nw_data <= swap_bytes({32'd0, num_base} + 64'(pend_idx));
        end
    end

    // R8: request held steady while stalled
    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nw_valid && !nw_ready) |=> (nw_valid && $stable(nw_addr) && $stable(nw_data)));

    // R6: a write only starts when the address enable was set
    p_send_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nw_valid) |-> $past(addr_ok));

endmodule

// File: rtl/irqn_notify_gen.sv
module irqn_notify_gen
    import irqn_pkg::*;
#(
    parameter int AW      = 8,
    parameter int NUM_SRC = 20,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               cfg_wr,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [63:0]        cfg_wdata,
    output logic [63:0]        cfg_rdata,
    output logic               src_refused,
    output logic               nw_valid,
    input  logic               nw_ready,
    output logic [63:0]        nw_addr,
    output logic [63:0]        nw_data
);

    logic [NUM_SRC-1:0] level_q;
    logic               method_lvl;
    logic               clear_req;
    logic [63:0]        notif_addr;
    logic [31:0]        num_base;
    logic               grant;
    logic               drop_all;
    logic               pend_any;
    logic [IDX_W-1:0]   pend_idx;

    irqn_regs #(.AW(AW), .NUM_SRC(NUM_SRC)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .level_q    (level_q),
        .method_lvl (method_lvl),
        .clear_req  (clear_req),
        .notif_addr (notif_addr),
        .num_base   (num_base)
    );

    irqn_src_track #(.NUM_SRC(NUM_SRC)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_level  (src_level),
        .method_lvl (method_lvl),
        .clear_req  (clear_req),
        .grant      (grant),
        .drop_all   (drop_all),
        .level_q    (level_q),
        .pend_any   (pend_any),
        .pend_idx   (pend_idx),
        .refused    (src_refused)
    );

    irqn_sender #(.NUM_SRC(NUM_SRC)) send_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (pend_any),
        .pend_idx   (pend_idx),
        .notif_addr (notif_addr),
        .num_base   (num_base),
        .grant      (grant),
        .drop_all   (drop_all),
        .nw_valid   (nw_valid),
        .nw_ready   (nw_ready),
        .nw_addr    (nw_addr),
        .nw_data    (nw_data)
    );

endmodule

// File: tb/irqn_notify_gen_tb_top.sv
module irqn_notify_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src_level = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        src_refused;
    logic        nw_valid;
    logic        nw_ready = 1'b0;
    logic [63:0] nw_addr;
    logic [63:0] nw_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_notif;
    logic [31:0] m_base;

    always #2 clk = ~clk;

    irqn_notify_gen dut_i (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .src_refused(src_refused),
        .nw_valid(nw_valid), .nw_ready(nw_ready),
        .nw_addr(nw_addr), .nw_data(nw_data)
    );

    function automatic logic [63:0] be64(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[63-8*b -: 8] = v[8*b +: 8];
        return r;
    endfunction

    function automatic logic [63:0] exp_levels(input logic [19:0] s);
        logic [63:0] r = '0;
        for (int n = 0; n < 20; n++) r[63-n] = s[n];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [63:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic expect_write(input int idx, input string req);
        bit seen = 0;
        for (int t = 0; t < 60 && !seen; t++) begin
            @(negedge clk);
            if (nw_valid) seen = 1;
        end
        check(seen, req, 64'(nw_valid), 64'd1);
        if (seen) begin
            check(nw_addr == {m_notif[63:1], 1'b0}, req, nw_addr, {m_notif[63:1], 1'b0});
            check(nw_data == be64({32'd0, m_base} + 64'(idx)), req, nw_data,
                  be64({32'd0, m_base} + 64'(idx)));
            nw_ready = 1'b1;
            @(negedge clk);
            nw_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input int cyc, input string req);
        bit any = 0;
        for (int t = 0; t < cyc; t++) begin
            @(negedge clk);
            if (nw_valid) any = 1;
        end
        check(!any, req, 64'(any), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic [63:0] a0, d0;
        logic [19:0] mask;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!nw_valid && !src_refused, "R1", {62'd0, nw_valid, src_refused}, 64'd0);
        cfg_read(8'h58, rd); check(rd == 0, "R1 ctrl", rd, 0);
        cfg_read(8'h60, rd); check(rd == 0, "R1 evbase", rd, 0);
        cfg_read(8'h68, rd); check(rd == 0, "R1 naddr", rd, 0);
        cfg_read(8'h70, rd); check(rd == 0, "R1 nbase", rd, 0);
        cfg_read(8'h78, rd); check(rd == 0, "R1 level", rd, 0);

        // R2 register access
        cfg_write(8'h60, 64'hDEAD_BEEF_0123_4567);
        cfg_read(8'h60, rd); check(rd == 64'hDEAD_BEEF_0123_4567, "R2 evbase", rd, 64'hDEAD_BEEF_0123_4567);
        cfg_write(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_read(8'h78, rd); check(rd == 0, "R2 level write ignored", rd, 0);
        cfg_read(8'h40, rd); check(rd == '1, "R2 unknown", rd, '1);
        cfg_read(8'h5C, rd); check(rd == '1, "R2 misaligned", rd, '1);

        m_notif = 64'h0000_1234_5678_9AB1;
        m_base  = 32'h0000_1000;
        cfg_write(8'h68, m_notif);
        cfg_write(8'h70, {m_base, 32'hCAFE_F00D});
        cfg_read(8'h68, rd); check(rd == m_notif, "R2 naddr", rd, m_notif);
        cfg_read(8'h70, rd); check(rd == {m_base, 32'hCAFE_F00D}, "R2 nbase", rd, {m_base, 32'hCAFE_F00D});

        // R4 exact latency and payload
        @(negedge clk);
        src_level[4] = 1'b1;
        @(negedge clk);
        check(!nw_valid, "R4 latency one clock", 64'(nw_valid), 0);
        cfg_read(8'h78, rd); check(rd == exp_levels(20'h10), "R3 level bit", rd, exp_levels(20'h10));
        @(negedge clk);
        check(nw_valid, "R4 latency two clocks", 64'(nw_valid), 1);
        expect_write(4, "R4 payload");
        // R5 no repeat while held high
        expect_quiet(12, "R5 held high");
        src_level[4] = 1'b0;
        repeat (2) @(negedge clk);
        src_level[4] = 1'b1;
        expect_write(4, "R5 re-arm after fall");
        src_level = '0;

        // R8 stall hold
        @(negedge clk);
        src_level[9] = 1'b1;
        repeat (3) @(negedge clk);
        a0 = nw_addr; d0 = nw_data;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            check(nw_valid && nw_addr == a0 && nw_data == d0, "R8 stall hold", nw_data, d0);
        end
        expect_write(9, "R8 after stall");
        src_level = '0;

        // R6 address enable clear
        m_notif = m_notif & ~64'd1;
        cfg_write(8'h68, m_notif);
        src_level[1] = 1'b1;
        expect_quiet(8, "R6 disabled");
        m_notif = m_notif | 64'd1;
        cfg_write(8'h68, m_notif);
        expect_quiet(8, "R6 dropped stays dropped");
        src_level = '0;
        repeat (2) @(negedge clk);

        // R9 method bit refuses changes
        cfg_write(8'h58, 64'h8000_0000_0000_0000);
        src_level[3] = 1'b1;
        @(negedge clk);
        check(src_refused, "R9 refused flag", 64'(src_refused), 1);
        cfg_read(8'h78, rd); check(rd == 0, "R9 level held", rd, 0);
        expect_quiet(6, "R9 no write");
        cfg_write(8'h58, 64'h0);
        expect_write(3, "R9 after method cleared");
        src_level = '0;
        repeat (2) @(negedge clk);

        // R10 clear with one write stalled and one queued
        src_level[2] = 1'b1; src_level[5] = 1'b1;
        repeat (3) @(negedge clk);
        src_level = '0;
        repeat (2) @(negedge clk);
        cfg_write(8'h58, 64'h4000_0000_0000_0000);
        cfg_read(8'h58, rd); check(rd == 0, "R10 clear bit reads 0", rd, 0);
        expect_write(2, "R10 in-flight kept");
        expect_quiet(10, "R10 queued cleared");
        // R10 level register cleared while method holds it
        src_level[7] = 1'b1;
        repeat (2) @(negedge clk);
        expect_write(7, "R10 setup");
        cfg_write(8'h58, 64'h8000_0000_0000_0000);
        cfg_read(8'h78, rd); check(rd == exp_levels(20'h80), "R10 level before", rd, exp_levels(20'h80));
        cfg_write(8'h58, 64'hC000_0000_0000_0000);
        cfg_read(8'h78, rd); check(rd == 0, "R10 level cleared", rd, 0);
        cfg_write(8'h58, 64'h0);
        expect_write(7, "R10 re-edge after clear");
        src_level = '0;
        repeat (2) @(negedge clk);

        // R7 random rounds, lowest index first
        for (int it = 0; it < 20; it++) begin
            mask = 20'($urandom) | 20'h1 << ($urandom % 20);
            m_base  = $urandom;
            m_notif = {$urandom, $urandom} | 64'd1;
            cfg_write(8'h68, m_notif);
            cfg_write(8'h70, {m_base, $urandom});
            @(negedge clk);
            src_level = mask;
            @(negedge clk);
            cfg_read(8'h78, rd); check(rd == exp_levels(mask), "R3 random levels", rd, exp_levels(mask));
            for (int n = 0; n < 20; n++) begin
                if (mask[n]) expect_write(n, "R7 order");
            end
            expect_quiet(3, "R7 no extra");
            src_level = '0;
            repeat (2) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule